// File: doc/BRIEF.md
# PLL Configuration Sequencer

The block reprograms one phase-locked loop from a single request. The request holds three divider values: the reference divider NR, the feedback multiplier NF and the output divider NO. After a one-cycle `start` it first puts the PLL into slow mode with its reset asserted. It then writes the divider fields in a fixed order, each one stored as its value minus one, and sets the bandwidth-adjust field from NF. Next it holds reset for a settle time measured in microseconds and releases it. From then on it samples the lock input once per microsecond. When lock is seen it moves the PLL into normal mode.

A microsecond tick is derived from the system clock frequency parameter. A lock-timeout counter ends the sequence with an error if lock never comes, and the PLL is then left in slow mode. A request with any zero divider is refused at once and nothing is written.

The block also drives a registered rate output from the current mode and divider fields. It shows the 24 MHz reference in slow mode and 24 MHz × NF / (NR × NO), truncated to whole hertz, in normal mode. Any other mode code shows 32768 Hz.

Top module: `pll_prog_seq`

## Requirements
- R1: After reset, busy, done and err are 0, the mode field is slow (code 0), the PLL reset output is 0, all divider and bandwidth fields are 0, and rateHz reads 24000000.
- R2: A start whose NR, NO or NF is zero is refused. done and err are 1 in the cycle after start, busy stays 0, and no field, mode or rate changes.
- R3: For an accepted request, the first write sets the mode to slow and the PLL reset to 1 in the same cycle. The NR/NO fields follow one cycle later, the NF field one cycle after that, and the bandwidth field one cycle after that.
- R4: The fields hold the request values minus one: pllNrField = NR−1, pllNoField = NO−1, pllNfField = NF−1.
- R5: pllBwField = (NF >> 1) − 1, truncated to the field width. NF = 1 therefore gives all ones.
- R6: The PLL reset stays asserted for at least SETTLE_US microseconds (SETTLE_US × CLK_HZ/1e6 clock cycles) before it is released.
- R7: Lock is sampled only on microsecond ticks after reset release. The mode becomes normal (code 1) only after lock has been seen, together with a one-cycle done and err = 0.
- R8: If no lock is seen within LOCK_TIMEOUT_US microseconds of release, done pulses with err = 1 and the mode stays slow.
- R9: rateHz is 24000000 in slow mode and 24000000·(nf+1)/((nr+1)(no+1)) in normal mode, where nf, nr and no are the field values. It follows a field or mode change one cycle later.
- R10: A start received while busy is ignored. The sequence finishes with the fields of the first request.
- R11: busy is 1 from the cycle after an accepted start until done. err is cleared by an accepted start, and done lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request strobe |
| reqNr | input | NR_W (6) | Requested reference divider |
| reqNo | input | NO_W (4) | Requested output divider |
| reqNf | input | NF_W (13) | Requested feedback multiplier |
| pllLock | input | 1 | Lock status from the PLL |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Last request refused or timed out |
| pllMode | output | 2 | PLL mode field: 0 slow, 1 normal, 2 deep slow |
| pllReset | output | 1 | PLL reset control |
| pllNrField | output | NR_W (6) | Reference divider field (NR−1) |
| pllNoField | output | NO_W (4) | Output divider field (NO−1) |
| pllNfField | output | NF_W (13) | Feedback field (NF−1) |
| pllBwField | output | NF_W−1 (12) | Bandwidth-adjust field |
| rateHz | output | RATE_W (39) | Effective output rate in Hz |

## Verification
The hardest situation to reach from the ports is a second start that arrives while a sequence is already running. The stimulus pulses `start` with different dividers during the settle wait and expects the final fields to match the first request. A second hard case is the lock timeout, which the bench reaches by holding its PLL model out of lock for the whole window. After the timeout it checks that the mode stays slow, and it then runs a good request to confirm that the error clears. The order of the field writes is checked cycle by cycle against the values the bench expects.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;
  localparam int unsigned REF_HZ  = 24_000_000;
  localparam int unsigned DEEP_HZ = 32_768;

  typedef enum logic [1:0] {
    MODE_SLOW   = 2'd0,
    MODE_NORMAL = 2'd1,
    MODE_DEEP   = 2'd2
  } pllMode_e;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_SLOW,
    ST_DIV,
    ST_NF,
    ST_BW,
    ST_SETTLE,
    ST_RELEASE,
    ST_POLL,
    ST_NORMAL
  } seqState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;
    logic wrSlowRst;
    logic wrDiv;
    logic wrNf;
    logic wrBw;
    logic relRst;
    logic wrNormal;
    logic tmrClr;
  } seqStrobe_t;
endpackage

// File: rtl/pll_seq_dp.sv
module pll_seq_dp
  import pll_seq_pkg::*;
#(
  parameter int CLK_HZ = 24_000_000,
  parameter int NR_W   = 6,
  parameter int NO_W   = 4,
  parameter int NF_W   = 13,
  parameter int US_W   = 11,
  parameter int RATE_W = 39
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strobe,
  input  logic [NR_W-1:0]   reqNr,
  input  logic [NO_W-1:0]   reqNo,
  input  logic [NF_W-1:0]   reqNf,
  output logic              usTick,
  output logic [US_W-1:0]   usCount,
  output logic [1:0]        pllMode,
  output logic              pllReset,
  output logic [NR_W-1:0]   nrField,
  output logic [NO_W-1:0]   noField,
  output logic [NF_W-1:0]   nfField,
  output logic [NF_W-2:0]   bwField,
  output logic [RATE_W-1:0] rateHz
);
  localparam int CYC_PER_US = CLK_HZ / 1_000_000;
  localparam int PRE_W      = (CYC_PER_US > 1) ? $clog2(CYC_PER_US) : 1;
  localparam int BW_W       = NF_W - 1;
  localparam int DEN_W      = NR_W + NO_W + 1;

  logic [PRE_W-1:0] preCnt;
  logic [NR_W-1:0]  capNr;
  logic [NO_W-1:0]  capNo;
  logic [NF_W-1:0]  capNf;

  // microsecond tick generator
  assign usTick = (preCnt == PRE_W'(CYC_PER_US - 1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      preCnt  <= '0;
      usCount <= '0;
    end else if (strobe.tmrClr) begin
      preCnt  <= '0;
      usCount <= '0;
    end else if (usTick) begin
      preCnt  <= '0;
      usCount <= usCount + US_W'(1);
    end else begin
      preCnt  <= preCnt + PRE_W'(1);
    end
  end

  // request capture
  always_ff @(posedge clk) begin
    if (!rstN) begin
      capNr <= '0;
      capNo <= '0;
      capNf <= '0;
    end else if (strobe.capture) begin
      capNr <= reqNr;
      capNo <= reqNo;
      capNf <= reqNf;
    end
  end

  // PLL control fields
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pllMode  <= MODE_SLOW;
      pllReset <= 1'b0;
      nrField  <= '0;
      noField  <= '0;
      nfField  <= '0;
      bwField  <= '0;
    end else begin
      if (strobe.wrSlowRst) begin
        pllMode  <= MODE_SLOW;
        pllReset <= 1'b1;
      end
      if (strobe.wrDiv) begin
        nrField <= capNr - NR_W'(1);
        noField <= capNo - NO_W'(1);
      end
      if (strobe.wrNf)     nfField  <= capNf - NF_W'(1);
      if (strobe.wrBw)     bwField  <= capNf[NF_W-1:1] - BW_W'(1);
      if (strobe.relRst)   pllReset <= 1'b0;
      if (strobe.wrNormal) pllMode  <= MODE_NORMAL;
    end
  end

  // rate decode
  logic [RATE_W-1:0] numer;
  logic [DEN_W-1:0]  denom;
  logic [RATE_W-1:0] rateNext;

  always_comb begin
    numer = RATE_W'(REF_HZ) * (RATE_W'(nfField) + RATE_W'(1));
    denom = (DEN_W'(nrField) + DEN_W'(1)) * (DEN_W'(noField) + DEN_W'(1));
    case (pllMode)
      MODE_SLOW:   rateNext = RATE_W'(REF_HZ);
      MODE_NORMAL: rateNext = numer / RATE_W'(denom);
      default:     rateNext = RATE_W'(DEEP_HZ);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) rateHz <= RATE_W'(REF_HZ);
    else       rateHz <= rateNext;
  end

  p_reset_enters_slow_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pllReset) |-> (pllMode == MODE_SLOW));

  p_tick_spacing_r6: assert property (@(posedge clk) disable iff (!rstN)
    (usTick && (CYC_PER_US > 1)) |=> !usTick);
endmodule

// File: rtl/pll_seq_ctrl.sv
module pll_seq_ctrl
  import pll_seq_pkg::*;
#(
  parameter int SETTLE_US       = 10,
  parameter int LOCK_TIMEOUT_US = 1000,
  parameter int US_W            = 11
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            start,
  input  logic            reqZero,
  input  logic            usTick,
  input  logic [US_W-1:0] usCount,
  input  logic            pllLock,
  output seqStrobe_t      strobe,
  output logic            busy,
  output logic            done,
  output logic            err
);
  seqState_e state, stNext;
  logic badStart, goodStart, lockSeen, lockFail;

  assign badStart  = (state == ST_IDLE) && start && reqZero;
  assign goodStart = (state == ST_IDLE) && start && !reqZero;
  assign lockSeen  = (state == ST_POLL) && usTick && pllLock;
  assign lockFail  = (state == ST_POLL) && usTick && !pllLock &&
                     (usCount >= US_W'(LOCK_TIMEOUT_US - 1));
  assign busy      = (state != ST_IDLE);

  always_comb begin
    stNext = state;
    strobe = '0;
    case (state)
      ST_IDLE: if (goodStart) begin
        strobe.capture = 1'b1;
        stNext         = ST_SLOW;
      end
      ST_SLOW: begin
        strobe.wrSlowRst = 1'b1;
        stNext           = ST_DIV;
      end
      ST_DIV: begin
        strobe.wrDiv = 1'b1;
        stNext       = ST_NF;
      end
      ST_NF: begin
        strobe.wrNf = 1'b1;
        stNext      = ST_BW;
      end
      ST_BW: begin
        strobe.wrBw   = 1'b1;
        strobe.tmrClr = 1'b1;
        stNext        = ST_SETTLE;
      end
      ST_SETTLE: if (usCount >= US_W'(SETTLE_US)) stNext = ST_RELEASE;
      ST_RELEASE: begin
        strobe.relRst = 1'b1;
        strobe.tmrClr = 1'b1;
        stNext        = ST_POLL;
      end
      ST_POLL: begin
        if (lockSeen)      stNext = ST_NORMAL;
        else if (lockFail) stNext = ST_IDLE;
      end
      ST_NORMAL: begin
        strobe.wrNormal = 1'b1;
        stNext          = ST_IDLE;
      end
      default: stNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      done  <= 1'b0;
      err   <= 1'b0;
    end else begin
      state <= stNext;
      done  <= badStart || lockFail || (state == ST_NORMAL);
      if (goodStart)                 err <= 1'b0;
      else if (badStart || lockFail) err <= 1'b1;
    end
  end

  p_bad_start_idle_r2: assert property (@(posedge clk) disable iff (!rstN)
    (start && reqZero && !busy) |=> (!busy && done && err));

  p_lock_before_normal_r7: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_NORMAL) |-> ($past(pllLock) && $past(usTick)));

  p_settle_elapsed_r6: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RELEASE) |-> (usCount >= US_W'(SETTLE_US)));

  p_done_ends_busy_r11: assert property (@(posedge clk) disable iff (!rstN)
    (done && !err) |-> (!busy && $past(busy)));
endmodule

// File: rtl/pll_prog_seq.sv
module pll_prog_seq
  import pll_seq_pkg::*;
#(
  parameter int CLK_HZ          = 24_000_000,
  parameter int NR_W            = 6,
  parameter int NO_W            = 4,
  parameter int NF_W            = 13,
  parameter int SETTLE_US       = 10,
  parameter int LOCK_TIMEOUT_US = 1000,
  localparam int RATE_W         = $clog2(REF_HZ) + NF_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [NR_W-1:0]   reqNr,
  input  logic [NO_W-1:0]   reqNo,
  input  logic [NF_W-1:0]   reqNf,
  input  logic              pllLock,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic [1:0]        pllMode,
  output logic              pllReset,
  output logic [NR_W-1:0]   pllNrField,
  output logic [NO_W-1:0]   pllNoField,
  output logic [NF_W-1:0]   pllNfField,
  output logic [NF_W-2:0]   pllBwField,
  output logic [RATE_W-1:0] rateHz
);
  localparam int US_MAX = (LOCK_TIMEOUT_US > SETTLE_US) ? LOCK_TIMEOUT_US : SETTLE_US;
  localparam int US_W   = $clog2(US_MAX + 2);

  seqStrobe_t      strobe;
  logic            usTick;
  logic [US_W-1:0] usCount;
  logic            reqZero;

  assign reqZero = (reqNr == '0) || (reqNo == '0) || (reqNf == '0);

  pll_seq_ctrl #(
    .SETTLE_US(SETTLE_US), .LOCK_TIMEOUT_US(LOCK_TIMEOUT_US), .US_W(US_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .reqZero(reqZero),
    .usTick(usTick), .usCount(usCount), .pllLock(pllLock),
    .strobe(strobe), .busy(busy), .done(done), .err(err)
  );

  pll_seq_dp #(
    .CLK_HZ(CLK_HZ), .NR_W(NR_W), .NO_W(NO_W), .NF_W(NF_W),
    .US_W(US_W), .RATE_W(RATE_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .reqNr(reqNr), .reqNo(reqNo), .reqNf(reqNf),
    .usTick(usTick), .usCount(usCount),
    .pllMode(pllMode), .pllReset(pllReset),
    .nrField(pllNrField), .noField(pllNoField), .nfField(pllNfField),
    .bwField(pllBwField), .rateHz(rateHz)
  );

  p_timeout_keeps_slow_r8: assert property (@(posedge clk) disable iff (!rstN)
    (done && err && $past(busy)) |-> (pllMode == MODE_SLOW));
endmodule

// File: tb/pll_prog_seq_tb.sv
module pll_prog_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int CLK_HZ     = 24_000_000;
  localparam int CYC_US     = CLK_HZ / 1_000_000;
  localparam int SETTLE_US  = 10;
  localparam int LOCK_DLY   = 77;
  localparam longint REF    = 24_000_000;

  logic clk = 1'b0, rstN = 1'b0, start = 1'b0, pllLock = 1'b0;
  logic [5:0]  reqNr = '0;
  logic [3:0]  reqNo = '0;
  logic [12:0] reqNf = '0;
  logic busy, done, err, pllReset;
  logic [1:0]  pllMode;
  logic [5:0]  pllNrField;
  logic [3:0]  pllNoField;
  logic [12:0] pllNfField;
  logic [11:0] pllBwField;
  logic [38:0] rateHz;

  bit lockEn = 1'b1;
  int checks = 0, errors = 0;

  typedef struct {
    logic       errE;
    logic [1:0] modeE;
    longint     nrE, noE, nfE, bwE, rateE;
    string      tag;
  } expItem_t;
  expItem_t expQ[$];

  // bench model of the PLL field state
  longint mMode = 0, mNr = 0, mNo = 0, mNf = 0, mBw = 0, mRate = REF;

  always #(CLK_PERIOD/2) clk = ~clk;

  pll_prog_seq u_dut (
    .clk(clk), .rstN(rstN), .start(start), .reqNr(reqNr), .reqNo(reqNo),
    .reqNf(reqNf), .pllLock(pllLock), .busy(busy), .done(done), .err(err),
    .pllMode(pllMode), .pllReset(pllReset), .pllNrField(pllNrField),
    .pllNoField(pllNoField), .pllNfField(pllNfField),
    .pllBwField(pllBwField), .rateHz(rateHz)
  );

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic longint calcRate(longint mode, longint nrF, longint noF, longint nfF);
    if (mode == 0) return REF;
    if (mode == 1) return REF * (nfF + 1) / ((nrF + 1) * (noF + 1));
    return 32768;
  endfunction

  // PLL model: lock rises LOCK_DLY cycles after reset release
  int lockCnt = 0;
  always @(negedge clk) begin
    if (pllReset || !lockEn) begin
      lockCnt = 0;
      pllLock = 1'b0;
    end else if (lockCnt >= LOCK_DLY) pllLock = 1'b1;
    else lockCnt = lockCnt + 1;
  end

  // settle time monitor (R6)
  int rstLen = 0;
  always @(negedge clk) begin
    if (rstN) begin
      if (pllReset) rstLen++;
      else if (rstLen != 0) begin
        check(rstLen >= SETTLE_US * CYC_US, "R6", "reset hold cycles",
              rstLen, SETTLE_US * CYC_US);
        rstLen = 0;
      end
    end
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (rstN && done) begin
      @(negedge clk);
      check(!done, "R11", "done width", done, 0);
      if (expQ.size() == 0) check(1'b0, "R11", "unexpected done", 1, 0);
      else begin
        automatic expItem_t e = expQ.pop_front();
        check(err == e.errE, e.tag, "err", err, e.errE);
        check(pllMode == e.modeE, e.tag, "mode", pllMode, e.modeE);
        check(pllNrField == e.nrE && pllNoField == e.noE, "R4", "nr/no fields",
              {pllNrField, pllNoField}, {e.nrE[5:0], e.noE[3:0]});
        check(pllNfField == e.nfE, "R4", "nf field", pllNfField, e.nfE);
        check(pllBwField == e.bwE, "R5", "bw field", pllBwField, e.bwE);
        check(rateHz == e.rateE, "R9", "rate", rateHz, e.rateE);
      end
    end
  end

  task automatic pulseStart(int nr, int no, int nf);
    @(negedge clk);
    reqNr = 6'(nr); reqNo = 4'(no); reqNf = 13'(nf);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic runGood(int nr, int no, int nf, bit lockOn, bit overlap);
    expItem_t e;
    longint bw;
    bw = ((nf >> 1) - 1) & 12'hFFF;
    lockEn = lockOn;
    e.errE  = !lockOn;
    e.modeE = lockOn ? 2'd1 : 2'd0;
    e.nrE = nr - 1; e.noE = no - 1; e.nfE = nf - 1; e.bwE = bw;
    e.rateE = calcRate(e.modeE, e.nrE, e.noE, e.nfE);
    e.tag = lockOn ? "R7" : "R8";
    expQ.push_back(e);
    mMode = e.modeE; mNr = e.nrE; mNo = e.noE; mNf = e.nfE; mBw = bw; mRate = e.rateE;
    pulseStart(nr, no, nf);
    check(busy == 1'b1, "R11", "busy after start", busy, 1);
    check(err == 1'b0, "R11", "err cleared", err, 0);
    while (!pllReset) @(negedge clk);
    check(pllMode == 2'd0, "R3", "slow with reset", pllMode, 0);
    @(negedge clk);
    check(pllNrField == 6'(nr - 1) && pllNoField == 4'(no - 1), "R3", "nr/no second",
          {pllNrField, pllNoField}, {6'(nr - 1), 4'(no - 1)});
    @(negedge clk);
    check(pllNfField == 13'(nf - 1), "R3", "nf third", pllNfField, nf - 1);
    @(negedge clk);
    check(pllBwField == 12'(bw), "R3", "bw fourth", pllBwField, bw);
    if (overlap) begin
      repeat (20) @(negedge clk);
      pulseStart(2, 2, 50);  // R10: must be ignored
    end
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
    check(expQ.size() == 0, e.tag, "done seen", expQ.size(), 0);
  endtask

  task automatic runBad(int nr, int no, int nf);
    expItem_t e;
    e.errE = 1'b1; e.modeE = 2'(mMode);
    e.nrE = mNr; e.noE = mNo; e.nfE = mNf; e.bwE = mBw; e.rateE = mRate;
    e.tag = "R2";
    expQ.push_back(e);
    pulseStart(nr, no, nf);
    check(busy == 1'b0, "R2", "busy stays low", busy, 0);
    check(done == 1'b1, "R2", "done next cycle", done, 1);
    repeat (3) @(negedge clk);
    check(expQ.size() == 0, "R2", "done seen", expQ.size(), 0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(!busy && !done && !err, "R1", "status idle", {busy, done, err}, 0);
    check(pllMode == 2'd0 && !pllReset, "R1", "mode/reset", {pllMode, pllReset}, 0);
    check(pllNrField == 0 && pllNoField == 0 && pllNfField == 0 && pllBwField == 0,
          "R1", "fields zero", pllNfField, 0);
    check(rateHz == 39'(REF), "R1", "rate slow", rateHz, REF);

    runGood(1, 2, 68, 1'b1, 1'b0);     // 816 MHz
    runGood(12, 2, 800, 1'b1, 1'b1);   // 800 MHz, overlapped start (R10)
    runGood(3, 7, 100, 1'b1, 1'b0);    // truncated rate (R9)
    runBad(0, 2, 50);                  // R2
    runBad(4, 2, 0);                   // R2
    runGood(1, 1, 1, 1'b1, 1'b0);      // R5 all-ones bandwidth
    runGood(1, 6, 100, 1'b0, 1'b0);    // R8 timeout
    runGood(1, 2, 48, 1'b1, 1'b0);     // recovery, 576 MHz

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL R11 watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule